// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog that counts on a slow, free-running tick supplied as a one-cycle enable in the bus clock domain. The tick is nominally 40 kHz and does not depend on the bus clock rate. Software talks to it through four word registers: a key register, a divider-code register, a reload register and a status register. Key values written to the key register do three jobs. One value opens the divider and reload registers for writing. One value launches the countdown. One value refills the counter, and that value also closes the registers again. Once launched, the watchdog cannot be halted by any write.

The divider code picks a tick divider from 4 up to 256. The counter then steps down once per divided period. When the counter runs out, the block emits a one-cycle reset request and starts a fresh period on its own from the reload value. New divider and reload values move into the counting logic only on a tick. Until that tick, a busy flag for each register stays raised. A debug halt input stops the countdown, but only while the freeze enable input is also high.

Top module: `guard_wdt`

## Requirements
- R1: After reset the divider-code register (address 1) reads 0, the reload register (address 2) reads 0x0FFF, the status register (address 3) reads 0, the key register (address 0) reads 0 and `rst_req` is low.
- R2: A write to address 1 (bits 2:0) or address 2 (bits 11:0) changes the register only if the last key written was 0x5555. Any other key value closes the registers again.
- R3: In the status register, bit 0 is divider busy and bit 1 is reload busy. An accepted write raises the bit, and the bit clears at the first tick after that write.
- R4: Writing key 0xCCCC starts the watchdog. `rst_req` never rises before the start. After the start, no key value or other write stops the countdown.
- R5: After a start or refresh key write, the first tick loads the counter. `rst_req` then rises in the cycle after the tick that completes div × max(reload,1) further counted ticks, where div = 4 << min(code,6).
- R6: Writing key 0xAAAA reloads the counter at the next tick, which postpones the reset request. It also closes the registers to writes.
- R7: Divider code 7 gives the same divide-by-256 timing as code 6.
- R8: While `dbg_halt` and `frz_en` are both high, ticks are not counted and no reset request is raised. `dbg_halt` has no effect while `frz_en` is low.
- R9: `rst_req` is high for exactly one cycle. After it, the countdown restarts from the reload value without software action, which gives a periodic request every div × max(reload,1) ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle enable from the slow watchdog clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 key, 1 divider code, 2 reload, 3 status |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | 16 | Combinational read data |
| dbg_halt | input | 1 | Debug halt request |
| frz_en | input | 1 | Lets the debug halt freeze the countdown |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The hardest situation to reach is a reconfiguration of a watchdog that is already running. New divider and reload values reach the counting logic only on a tick, so a timeout that falls inside that window would use a mix of old and new settings. The stimulus holds the tick source while it unlocks, rewrites and refreshes, and then releases it. This makes the counter load deterministic. Random divider codes, reload values and refresh gaps are then applied on top, and every reset request is timed against a tick count computed in the bench. The busy flags are observed in the same way, with the tick held off.

// File: rtl/guard_wdt_pkg.sv
package guard_wdt_pkg;

   typedef enum logic [1:0] {
      REG_KEY    = 2'd0,
      REG_DIV    = 2'd1,
      REG_RELOAD = 2'd2,
      REG_STATUS = 2'd3
   } reg_sel_e;

   // codes above the last distinct one all select the largest divider
   function automatic int shift_of(input int code, input int max_code);
      return (code > max_code) ? max_code : code;
   endfunction

endpackage

// File: rtl/guard_wdt_keys.sv
module guard_wdt_keys #(
   parameter int                DATA_W     = 16,
   parameter logic [DATA_W-1:0] KEY_UNLOCK = 'h5555,
   parameter logic [DATA_W-1:0] KEY_START  = 'hCCCC,
   parameter logic [DATA_W-1:0] KEY_KICK   = 'hAAAA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_wr,
   input  logic [DATA_W-1:0] key_data,
   output logic              unlocked,
   output logic              running,
   output logic              kick_req
);

   logic is_unlock;
   logic is_start;
   logic is_kick;

   always_comb begin
      is_unlock = (key_data == KEY_UNLOCK);
      is_start  = (key_data == KEY_START);
      is_kick   = (key_data == KEY_KICK);
      kick_req  = key_wr && (is_start || is_kick);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unlocked <= 1'b0;
         running  <= 1'b0;
      end else if (key_wr) begin
         unlocked <= is_unlock;
         if (is_start) begin
            running <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/guard_wdt_cfg.sv
module guard_wdt_cfg #(
   parameter int           W             = 12,
   parameter logic [W-1:0] RESET_VAL     = '1,
   parameter bit           LATCH_ON_TICK = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         wr_ok,
   input  logic [W-1:0] wr_val,
   output logic [W-1:0] shadow,
   output logic [W-1:0] active,
   output logic         busy
);

   if (LATCH_ON_TICK) begin : g_latched
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            shadow <= RESET_VAL;
            active <= RESET_VAL;
            busy   <= 1'b0;
         end else begin
            if (wr_ok) begin
               shadow <= wr_val;
            end
            if (tick) begin
               active <= shadow;
            end
            if (wr_ok) begin
               busy <= 1'b1;
            end else if (tick) begin
               busy <= 1'b0;
            end
         end
      end
   end else begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            shadow <= RESET_VAL;
         end else if (wr_ok) begin
            shadow <= wr_val;
         end
      end
      assign active = shadow;
      assign busy   = 1'b0;
   end

endmodule

// File: rtl/guard_wdt_core.sv
module guard_wdt_core
   import guard_wdt_pkg::*;
#(
   parameter int RL_W       = 12,
   parameter int CODE_W     = 3,
   parameter int MAX_CODE   = 6,
   parameter int BASE_SHIFT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              freeze,
   input  logic              running,
   input  logic              kick_req,
   input  logic [RL_W-1:0]   load_val,
   input  logic [RL_W-1:0]   rl_act,
   input  logic [CODE_W-1:0] code_act,
   output logic              rst_req
);

   localparam int PRE_W = BASE_SHIFT + MAX_CODE;

   logic              kick_pend;
   logic [PRE_W-1:0]  pre_cnt;
   logic [PRE_W-1:0]  pre_lim;
   logic [RL_W-1:0]   cnt;
   logic              expire;

   always_comb begin
      pre_lim = PRE_W'((1 << (BASE_SHIFT + shift_of(int'(code_act), MAX_CODE))) - 1);
      expire  = (cnt < RL_W'(2));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kick_pend <= 1'b0;
         pre_cnt   <= '0;
         cnt       <= '1;
         rst_req   <= 1'b0;
      end else begin
         rst_req <= 1'b0;
         if (kick_req) begin
            kick_pend <= 1'b1;
         end else if (tick) begin
            kick_pend <= 1'b0;
         end
         if (tick) begin
            if (kick_pend) begin
               cnt     <= load_val;
               pre_cnt <= '0;
            end else if (running && !freeze) begin
               if (pre_cnt >= pre_lim) begin
                  pre_cnt <= '0;
                  if (expire) begin
                     cnt     <= rl_act;
                     rst_req <= 1'b1;
                  end else begin
                     cnt <= cnt - 1'b1;
                  end
               end else begin
                  pre_cnt <= pre_cnt + 1'b1;
               end
            end
         end
      end
   end

endmodule

// File: rtl/guard_wdt.sv
module guard_wdt
   import guard_wdt_pkg::*;
#(
   parameter int                DATA_W        = 16,
   parameter int                CODE_W        = 3,
   parameter int                RL_W          = 12,
   parameter int                MAX_CODE      = 6,
   parameter int                BASE_SHIFT    = 2,
   parameter bit                LATCH_ON_TICK = 1'b1,
   parameter logic [DATA_W-1:0] KEY_UNLOCK    = 'h5555,
   parameter logic [DATA_W-1:0] KEY_START     = 'hCCCC,
   parameter logic [DATA_W-1:0] KEY_KICK      = 'hAAAA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              dbg_halt,
   input  logic              frz_en,
   output logic              rst_req
);

   if (RL_W > DATA_W) begin : g_bad_rl
      $error("reload width exceeds data width");
   end
   if (CODE_W > DATA_W) begin : g_bad_code
      $error("code width exceeds data width");
   end
   if (MAX_CODE >= (1 << CODE_W)) begin : g_bad_max
      $error("largest distinct code does not fit the code field");
   end
   if (BASE_SHIFT + MAX_CODE > 30) begin : g_bad_div
      $error("divider range too large");
   end

   logic              unlocked;
   logic              running;
   logic              kick_req;
   logic              key_wr;
   logic              div_wr_ok;
   logic              rl_wr_ok;
   logic              freeze;
   logic [CODE_W-1:0] div_shadow;
   logic [CODE_W-1:0] div_active;
   logic              div_busy;
   logic [RL_W-1:0]   rl_shadow;
   logic [RL_W-1:0]   rl_active;
   logic              rl_busy;

   always_comb begin
      key_wr    = wr_en && (wr_addr == REG_KEY);
      div_wr_ok = wr_en && (wr_addr == REG_DIV) && unlocked;
      rl_wr_ok  = wr_en && (wr_addr == REG_RELOAD) && unlocked;
      freeze    = dbg_halt && frz_en;
   end

   guard_wdt_keys #(
      .DATA_W     (DATA_W),
      .KEY_UNLOCK (KEY_UNLOCK),
      .KEY_START  (KEY_START),
      .KEY_KICK   (KEY_KICK)
   ) i_keys (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_wr   (key_wr),
      .key_data (wr_data),
      .unlocked (unlocked),
      .running  (running),
      .kick_req (kick_req)
   );

   guard_wdt_cfg #(
      .W             (CODE_W),
      .RESET_VAL     ('0),
      .LATCH_ON_TICK (LATCH_ON_TICK)
   ) i_div_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .wr_ok  (div_wr_ok),
      .wr_val (wr_data[CODE_W-1:0]),
      .shadow (div_shadow),
      .active (div_active),
      .busy   (div_busy)
   );

   guard_wdt_cfg #(
      .W             (RL_W),
      .RESET_VAL     ('1),
      .LATCH_ON_TICK (LATCH_ON_TICK)
   ) i_rl_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .wr_ok  (rl_wr_ok),
      .wr_val (wr_data[RL_W-1:0]),
      .shadow (rl_shadow),
      .active (rl_active),
      .busy   (rl_busy)
   );

   guard_wdt_core #(
      .RL_W       (RL_W),
      .CODE_W     (CODE_W),
      .MAX_CODE   (MAX_CODE),
      .BASE_SHIFT (BASE_SHIFT)
   ) i_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .freeze   (freeze),
      .running  (running),
      .kick_req (kick_req),
      .load_val (rl_shadow),
      .rl_act   (rl_active),
      .code_act (div_active),
      .rst_req  (rst_req)
   );

   always_comb begin
      case (rd_addr)
         REG_DIV:    rd_data = DATA_W'(div_shadow);
         REG_RELOAD: rd_data = DATA_W'(rl_shadow);
         REG_STATUS: rd_data = DATA_W'({rl_busy, div_busy});
         default:    rd_data = '0;
      endcase
   end

endmodule

// File: rtl/guard_wdt_chk.sv
module guard_wdt_chk #(
   parameter int CODE_W        = 3,
   parameter int RL_W          = 12,
   parameter bit LATCH_ON_TICK = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              rst_req,
   input logic              running,
   input logic              unlocked,
   input logic              wr_en,
   input logic [1:0]        wr_addr,
   input logic              div_wr_ok,
   input logic              rl_wr_ok,
   input logic              div_busy,
   input logic              rl_busy,
   input logic [CODE_W-1:0] div_shadow,
   input logic [RL_W-1:0]   rl_shadow,
   input logic              freeze
);

   AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req); // R9
   AST_REQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> $past(tick)); // R5
   AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> !rst_req); // R4
   AST_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      running |=> running); // R4
   AST_LOCKED_DIV: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd1 && !unlocked) |=> $stable(div_shadow)); // R2
   AST_LOCKED_RL: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd2 && !unlocked) |=> $stable(rl_shadow)); // R2
   AST_FROZEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |=> !rst_req); // R8

   if (LATCH_ON_TICK) begin : g_busy_chk
      AST_DIV_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
         div_wr_ok |=> div_busy); // R3
      AST_DIV_BUSY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
         (div_busy && tick && !div_wr_ok) |=> !div_busy); // R3
      AST_RL_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
         rl_wr_ok |=> rl_busy); // R3
      AST_RL_BUSY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
         (rl_busy && tick && !rl_wr_ok) |=> !rl_busy); // R3
   end

endmodule

bind guard_wdt guard_wdt_chk #(
   .CODE_W        (CODE_W),
   .RL_W          (RL_W),
   .LATCH_ON_TICK (LATCH_ON_TICK)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick       (tick),
   .rst_req    (rst_req),
   .running    (running),
   .unlocked   (unlocked),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .div_wr_ok  (div_wr_ok),
   .rl_wr_ok   (rl_wr_ok),
   .div_busy   (div_busy),
   .rl_busy    (rl_busy),
   .div_shadow (div_shadow),
   .rl_shadow  (rl_shadow),
   .freeze     (freeze)
);

// File: tb/test_guard_wdt.sv
module test_guard_wdt;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = 2'd0;
   logic [15:0] wr_data = 16'd0;
   logic [1:0]  rd_addr = 2'd0;
   logic [15:0] rd_data;
   logic        dbg_halt = 1'b0;
   logic        frz_en = 1'b0;
   logic        rst_req;

   always #5 clk = ~clk;

   guard_wdt i_guard_wdt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .dbg_halt (dbg_halt),
      .frz_en   (frz_en),
      .rst_req  (rst_req)
   );

   int n_checks = 0;
   int n_errs   = 0;
   bit done     = 1'b0;
   bit tick_hold = 1'b0;

   // bench model
   bit lock_m    = 1'b1;
   int code_m    = 0;
   int rl_m      = 4095;
   bit started_m = 1'b0;
   int eff       = 0;
   int exp_at    = 0;
   bit exp_on    = 1'b0;
   int fires     = 0;

   function automatic int div_of(input int code);
      return 4 << ((code > 6) ? 6 : code);
   endfunction

   function automatic int period_of(input int code, input int rl);
      return div_of(code) * ((rl == 0) ? 1 : rl);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int expv);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // tick source: one pulse every three cycles unless held
   initial begin
      forever begin
         repeat (2) @(posedge clk);
         #1 tick = !tick_hold;
         @(posedge clk);
         #1 tick = 1'b0;
      end
   end

   // timing monitor (R5, R9, R4, R8)
   always @(negedge clk) begin
      if (rst_n) begin
         if (tick && !(dbg_halt && frz_en)) eff++;
         if (rst_req) begin
            fires++;
            if (!started_m) check(1'b0, "R4 request before start", 1, 0);
            else check(exp_on && eff == exp_at, "R5 request timing", eff, exp_at);
            exp_at = eff + period_of(code_m, rl_m);
            exp_on = 1'b1;
         end else if (exp_on && eff > exp_at) begin
            check(1'b0, "R9 missed request", eff, exp_at);
            exp_on = 1'b0;
         end
         if (wr_en && wr_addr == 2'd0 &&
             (wr_data == 16'hCCCC || (wr_data == 16'hAAAA && started_m))) begin
            if (wr_data == 16'hCCCC) started_m = 1'b1;
            exp_at = eff + 1 + period_of(code_m, rl_m);
            exp_on = 1'b1;
         end
      end
   end

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      if (a == 2'd0) lock_m = (d != 16'h5555);
      else if (a == 2'd1 && !lock_m) code_m = int'(d[2:0]);
      else if (a == 2'd2 && !lock_m) rl_m = int'(d[11:0]);
      @(posedge clk);
      #1 wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] v);
      @(posedge clk);
      #1 rd_addr = a;
      #2 v = rd_data;
   endtask

   task automatic wait_ticks(input int n);
      repeat (n * 3) @(posedge clk);
   endtask

   task automatic reconfig(input int code, input int rl);
      tick_hold = 1'b1;
      repeat (3) @(posedge clk);
      wr(2'd0, 16'h5555);
      wr(2'd1, 16'(code));
      wr(2'd2, 16'(rl));
      wr(2'd0, 16'hAAAA);
      tick_hold = 1'b0;
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      logic [15:0] v;
      int f0;
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(2'd1, v); check(v == 16'h0, "R1 divider reset", v, 0);
      rd(2'd2, v); check(v == 16'h0FFF, "R1 reload reset", v, 16'h0FFF);
      rd(2'd3, v); check(v == 16'h0, "R1 status reset", v, 0);
      rd(2'd0, v); check(v == 16'h0, "R1 key reads zero", v, 0);
      check(rst_req == 1'b0, "R1 request low", rst_req, 0);

      // R2 locked writes ignored
      wr(2'd1, 16'h5);
      rd(2'd1, v); check(v == 16'h0, "R2 locked divider", v, 0);
      wr(2'd2, 16'h7);
      rd(2'd2, v); check(v == 16'h0FFF, "R2 locked reload", v, 16'h0FFF);

      // R2/R3 unlocked write and busy flags
      tick_hold = 1'b1;
      repeat (3) @(posedge clk);
      wr(2'd0, 16'h5555);
      wr(2'd1, 16'h2);
      rd(2'd1, v); check(v == 16'h2, "R2 unlocked divider", v, 2);
      rd(2'd3, v); check(v == 16'h1, "R3 divider busy", v, 1);
      wr(2'd2, 16'h3);
      rd(2'd3, v); check(v == 16'h3, "R3 both busy", v, 3);
      tick_hold = 1'b0;
      wait_ticks(2);
      rd(2'd3, v); check(v == 16'h0, "R3 busy cleared", v, 0);

      // R2 other key relocks
      wr(2'd0, 16'h1234);
      wr(2'd1, 16'h5);
      rd(2'd1, v); check(v == 16'h2, "R2 relocked divider", v, 2);

      // R4 no request before start
      wait_ticks(40);
      check(fires == 0, "R4 idle quiet", fires, 0);

      // R5/R9 start with div 4, reload 3
      tick_hold = 1'b1;
      repeat (3) @(posedge clk);
      wr(2'd0, 16'h5555);
      wr(2'd1, 16'h0);
      wr(2'd0, 16'hCCCC);
      tick_hold = 1'b0;
      f0 = fires;
      wait_ticks(62);
      check(fires - f0 >= 4, "R9 periodic requests", fires - f0, 4);

      // R6 refresh postpones and relocks
      f0 = fires;
      for (int i = 0; i < 10; i++) begin
         wr(2'd0, 16'hAAAA);
         wait_ticks(8);
      end
      check(fires == f0, "R6 refresh postpones", fires, f0);
      wr(2'd1, 16'h6);
      rd(2'd1, v); check(v == 16'h0, "R6 refresh relocks", v, 0);

      // R5 reload zero gives one divided period
      reconfig(0, 0);
      f0 = fires;
      wait_ticks(30);
      check(fires - f0 >= 5, "R5 reload zero", fires - f0, 5);

      // R7 code 7 equals code 6
      reconfig(7, 1);
      f0 = fires;
      wait_ticks(260);
      check(fires - f0 == 1, "R7 code 7 period", fires - f0, 1);
      reconfig(6, 1);
      f0 = fires;
      wait_ticks(260);
      check(fires - f0 == 1, "R7 code 6 period", fires - f0, 1);

      // R8 freeze
      reconfig(0, 5);
      wait_ticks(5);
      #1 frz_en = 1'b1; dbg_halt = 1'b1;
      f0 = fires;
      wait_ticks(40);
      check(fires == f0, "R8 frozen quiet", fires, f0);
      #1 dbg_halt = 1'b0;
      wait_ticks(20);
      check(fires > f0, "R8 resumes", fires, f0 + 1);
      #1 frz_en = 1'b0; dbg_halt = 1'b1;
      f0 = fires;
      wait_ticks(45);
      check(fires - f0 >= 2, "R8 halt ignored", fires - f0, 2);
      #1 dbg_halt = 1'b0;

      // R4 no key stops it
      for (int i = 0; i < 8; i++) begin
         logic [15:0] k;
         k = 16'($urandom_range(0, 16'hFFFF));
         if (k == 16'hAAAA || k == 16'hCCCC) k = 16'h0000;
         wr(2'd0, k);
      end
      f0 = fires;
      wait_ticks(45);
      check(fires - f0 >= 2, "R4 cannot stop", fires - f0, 2);

      // random configurations and refresh gaps (R5)
      for (int i = 0; i < 12; i++) begin
         reconfig($urandom_range(0, 2), $urandom_range(0, 15));
         wait_ticks($urandom_range(5, 60));
      end
      check(started_m, "R4 started", started_m, 1);

      finish_run();
   end

endmodule